// File: doc/BRIEF.md
# Sensor-Driven Intersection Light Controller

This block runs the signals of a four-way crossing where every approach has a left-turn lane, a straight lane and a right-turn lane. Each of the twelve lanes has a car detector that gives a one-cycle pulse per arrival. A car that arrives on a green lane just drives through. A car that arrives on a red lane becomes waiting demand, and the block keeps that demand until the lane turns green.

The controller moves through four phases in a fixed circular order. At each clock edge where demand is waiting, it jumps to the first phase after the current one that serves a waiting lane. When nothing is waiting, the lights stay as they are. There is no amber state, so a green goes straight to red. A right-turn arrow lights only in the phase where the approach on its right has its left arrow, because those two movements never meet.

Top module: `crossing_ctrl`

## Requirements
- R1: After reset, `phase_o` is 0 and `lights_o` is 12'h082, which means only the north- and southbound straight lanes are green.
- R2: Lane k (1..12) is sensed on `car_i[k-1]` and shown on `lights_o[k-1]`, with 1 meaning green. Lanes are numbered per approach as left, straight, right: northbound 1-3, westbound 4-6, southbound 7-9, eastbound 10-12. Each phase code shows exactly one green set: code 0 shows 12'h082, code 1 shows 12'h861, code 2 shows 12'h410 and code 3 shows 12'h30C.
- R3: No two conflicting movements are ever green together. This covers crossing straights, a left arrow against the opposing straight, and a right arrow against any flow that enters the same exit.
- R4: When a red lane has waiting demand, the phase changes at that same edge to the first phase, in the cyclic order 0,1,2,3,0, after the current phase that serves a waiting lane.
- R5: With no demand waiting on a red lane, the phase holds. A car that arrives on a green lane creates no demand.
- R6: A lane that is not served by the immediate switch stays waiting, and it is served within at most three phase changes.
- R7: When cars arrive in several lanes in the same tick, the controller switches away from the current phase. It serves the waiting phases in cyclic order.
- R8: The northbound and southbound right arrows (lanes 3, 9) are green only in phase 3. The westbound and eastbound right arrows (lanes 6, 12) are green only in phase 1.
- R9: Waiting demand clears once its lane has been green. With no new arrivals, the phase then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| car_i | input | 12 | One-cycle arrival pulse per lane |
| lights_o | output | 12 | Green flag per lane movement |
| phase_o | output | 2 | Active phase code |

## Verification
The intersection geometry is fixed, so the block has no parameters and the bench builds its only configuration. This makes all twelve lanes and all four phases reachable. Directed scenarios cover the cyclic search, including the wrap from phase 3 to phase 0, simultaneous arrivals that skip a phase with no demand, and right-arrow overlap. A long pseudo-random arrival stream then checks the exclusive green sets, the hold rule and the three-change service bound on every cycle.

// File: rtl/crossing_ctrl.sv
module crossing_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] car_i,
  output logic [11:0] lights_o,
  output logic [1:0]  phase_o
);

  localparam int          NPH      = 4;
  localparam logic [11:0] G_NS_STR = 12'h082;
  localparam logic [11:0] G_NS_LT  = 12'h861;
  localparam logic [11:0] G_EW_STR = 12'h410;
  localparam logic [11:0] G_EW_LT  = 12'h30C;

  function automatic logic [11:0] green_set(input logic [1:0] p);
    case (p)
      2'd0:    return G_NS_STR;
      2'd1:    return G_NS_LT;
      2'd2:    return G_EW_STR;
      default: return G_EW_LT;
    endcase
  endfunction

  logic [1:0]     phase_q, phase_d;
  logic [11:0]    pend_q, waiting;
  logic [NPH-1:0] want;

  assign lights_o = green_set(phase_q);
  assign phase_o  = phase_q;
  assign waiting  = (pend_q | car_i) & ~lights_o;

  for (genvar p = 0; p < NPH; p++) begin : g_want
    assign want[p] = |(waiting & green_set(2'(p)));
  end

  always_comb begin
    phase_d = phase_q;
    for (int k = NPH - 1; k >= 1; k--)
      if (want[phase_q + 2'(k)]) phase_d = phase_q + 2'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      pend_q  <= '0;
    end else begin
      phase_q <= phase_d;
      pend_q  <= waiting;
    end
  end

  a_r3_cross_straights: assert property (@(posedge clk) disable iff (!rst_n)
    !((lights_o[1] | lights_o[7]) & (lights_o[4] | lights_o[10])));
  a_r3_left_vs_opposing: assert property (@(posedge clk) disable iff (!rst_n)
    !((lights_o[0] & lights_o[7]) | (lights_o[6] & lights_o[1]) |
      (lights_o[3] & lights_o[10]) | (lights_o[9] & lights_o[4])));
  a_r3_right_exit: assert property (@(posedge clk) disable iff (!rst_n)
    !((lights_o[2] & (lights_o[10] | lights_o[6])) | (lights_o[8] & (lights_o[4] | lights_o[0])) |
      (lights_o[5] & (lights_o[1] | lights_o[9])) | (lights_o[11] & (lights_o[7] | lights_o[3]))));
  a_r4_demand_switches: assert property (@(posedge clk) disable iff (!rst_n)
    (|((pend_q | car_i) & ~lights_o)) |=> !$stable(phase_o));
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(|((pend_q | car_i) & ~lights_o)) |=> $stable(phase_o));
  a_r8_right_arrows: assert property (@(posedge clk) disable iff (!rst_n)
    ((lights_o[2] | lights_o[8]) |-> phase_o == 2'd3) and
    ((lights_o[5] | lights_o[11]) |-> phase_o == 2'd1));
  a_r9_served_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lights_o != 12'h000) |=> ((pend_q & $past(lights_o)) == 12'h000));

endmodule

// File: tb/crossing_ctrl_tb_top.sv
module crossing_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] car = '0;
  logic [11:0] lights;
  logic [1:0]  phase;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  crossing_ctrl dut_i (.clk(clk), .rst_n(rst_n), .car_i(car), .lights_o(lights), .phase_o(phase));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [11:0] exp_set(input logic [1:0] p);
    case (p)
      2'd0: return 12'h082;
      2'd1: return 12'h861;
      2'd2: return 12'h410;
      default: return 12'h30C;
    endcase
  endfunction

  function automatic bit conflict(input logic [11:0] g);
    return ((g[1] | g[7]) & (g[4] | g[10])) | (g[0] & g[7]) | (g[6] & g[1]) |
           (g[3] & g[10]) | (g[9] & g[4]) | (g[2] & (g[10] | g[6])) |
           (g[8] & (g[4] | g[0])) | (g[5] & (g[1] | g[9])) | (g[11] & (g[7] | g[3]));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_state(input string req, input logic [1:0] p);
    chk(phase == p, req, 16'(phase), 16'(p));
    chk(lights == exp_set(p), req, 16'(lights), 16'(exp_set(p)));
  endtask

  task automatic arrive(input logic [11:0] m);
    @(negedge clk) car = m;
    @(negedge clk) car = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_state("R1", 2'd0);
  endtask

  task automatic t_green_arrival();
    arrive(12'h002);
    expect_state("R5", 2'd0);
    step();
    expect_state("R5", 2'd0);
  endtask

  task automatic t_single_switch();
    arrive(12'h010);
    expect_state("R4", 2'd2);
    step();
    expect_state("R9", 2'd2);
  endtask

  task automatic t_simultaneous();
    arrive(12'h081);
    expect_state("R7", 2'd0);
    step();
    expect_state("R6", 2'd1);
    step();
    expect_state("R9", 2'd1);
  endtask

  task automatic t_right_turn();
    chk(lights[5] && lights[11] && !lights[2] && !lights[8], "R8", 16'(lights), 16'h861);
    arrive(12'h004);
    expect_state("R8", 2'd3);
    chk(lights[2] && lights[8] && !lights[5] && !lights[11], "R8", 16'(lights), 16'h30C);
    step();
    expect_state("R9", 2'd3);
  endtask

  task automatic t_multi_order();
    arrive(12'h800);
    expect_state("R4", 2'd1);
    step();
    expect_state("R9", 2'd1);
    arrive(12'h508);
    expect_state("R7", 2'd2);
    step();
    expect_state("R6", 2'd3);
    step();
    expect_state("R9", 2'd3);
  endtask

  task automatic t_wrap();
    arrive(12'h080);
    expect_state("R4", 2'd0);
    step();
    expect_state("R9", 2'd0);
  endtask

  task automatic t_stress();
    logic [31:0] r = 32'h1ACE_B00C;
    logic [11:0] wait_l = '0;
    int cnt[12];
    logic [1:0] prev_p;
    bit prev_dem = 1'b0;
    step();
    prev_p = phase;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      car = '0;
      chk(lights == exp_set(phase), "R2", 16'(lights), 16'(exp_set(phase)));
      chk(!conflict(lights), "R3", 16'(lights), 16'h0);
      if (prev_dem) chk(phase != prev_p, "R4", 16'(phase), 16'(prev_p));
      else          chk(phase == prev_p, "R5", 16'(phase), 16'(prev_p));
      for (int i = 0; i < 12; i++) begin
        if (wait_l[i]) begin
          if (phase != prev_p && !lights[i]) cnt[i]++;
          if (lights[i]) begin
            if (phase != prev_p) cnt[i]++;
            chk(cnt[i] <= 3, "R6", 16'(cnt[i]), 16'd3);
            wait_l[i] = 1'b0;
          end
        end
      end
      r = r ^ (r << 13);
      r = r ^ (r >> 17);
      r = r ^ (r << 5);
      if (n < 2990) car = r[11:0] & r[27:16] & {r[31:28], r[23:16]};
      for (int i = 0; i < 12; i++)
        if (car[i] && !lights[i] && !wait_l[i]) begin
          wait_l[i] = 1'b1;
          cnt[i] = 0;
        end
      prev_dem = (wait_l != 12'h000);
      prev_p = phase;
    end
    @(negedge clk) car = '0;
    chk(wait_l == 12'h000, "R6", 16'(wait_l), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_green_arrival();
    t_single_switch();
    t_simultaneous();
    t_right_turn();
    t_multi_order();
    t_wrap();
    t_stress();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule